// File: doc/BRIEF.md
# Resumable NMI Control Unit

This unit keeps the machine-level state for resumable non-maskable interrupts in a RISC-V style core. Four registers sit behind a CSR read/write port: a scratch word, the PC saved at NMI entry, a read-only cause word and an NMI status word. The status word holds an enable flag, the saved privilege and the saved virtualization mode. When an NMI request arrives while the enable flag is set, the unit takes the NMI in one cycle. It saves the interrupted PC, privilege and virtualization, clears the enable flag and sends the core to a fixed NMI vector.

The unit decodes the NMI-return instruction on the retiring instruction bus. In machine mode the return jumps to the saved PC, restores the saved privilege and virtualization, and sets the enable flag again. Below machine mode the return raises an illegal-instruction flag. While the enable flag is clear, the unit holds back ordinary interrupts and the modify-privilege feature for loads and stores. In that state a machine trap is sent to a separate, fixed exception address instead of the trap-vector target that the rest of the CSR file supplies.

Top module: `rnmi_ctrl`

## Requirements
- R1: After a synchronous reset, the status, scratch and saved-PC registers all read as zero, and no redirect or illegal flag is raised.
- R2: The CSR map is: 0x740 scratch (read/write), 0x741 saved PC, 0x742 cause, 0x744 status. The cause reads as only bit XLEN-1 set (0x80000000) and ignores writes. Any other address gives `csr_hit` = 0 and reads zero.
- R3: The status enable flag (bit 3) can be set by a CSR write. A CSR write with bit 3 at zero leaves the flag unchanged.
- R4: Status bits 12:11 hold the saved privilege (U=0, S=1, M=3). A written value of 2 is stored as U. Status bit 7 (saved virtualization) takes writes only while `hyp_en` is 1 and is cleared whenever `hyp_en` is 0. All other status bits read zero.
- R5: Bit 0 of the saved PC always reads as zero, both after a CSR write and after NMI entry.
- R6: When `nmi_req` is 1 and the enable flag is set, the unit redirects that cycle to the NMI vector with privilege M and virtualization 0. After the edge, the saved PC holds `cur_pc`, the status holds `cur_priv` and `cur_virt`, and the enable flag is clear. While the flag is clear, `nmi_req` has no effect.
- R7: Only the exact word 0x70200073 on a valid instruction, at privilege M, is an NMI return. It redirects to the saved PC with `new_priv` and `new_virt` taken from the status, and the enable flag is set after the edge.
- R8: `clr_mprv` is 1 during an NMI return exactly when the saved privilege is not M.
- R9: An NMI return seen below privilege M raises `illegal_instr`, gives no redirect and changes no state.
- R10: `irq_enable` and `mprv_enable` are 1 exactly when the enable flag is set.
- R11: When `trap_taken` is 1, the redirect target is `mtvec_target` if the enable flag is set, and the fixed exception address otherwise.
- R12: NMI entry wins over a trap, and a trap wins over an NMI return. A CSR write in a cycle with NMI entry or an NMI return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 12 | CSR address for read and write |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data (combinational) |
| csr_hit | output | 1 | Address belongs to this unit |
| nmi_req | input | 1 | NMI request from the source |
| cur_pc | input | XLEN | PC of the instruction being interrupted |
| cur_priv | input | 2 | Current privilege (U=0, S=1, M=3) |
| cur_virt | input | 1 | Current virtualization mode |
| hyp_en | input | 1 | Hypervisor extension enabled |
| instr_valid | input | 1 | Retiring instruction valid |
| instr | input | 32 | Retiring instruction word |
| trap_taken | input | 1 | A machine trap is being taken |
| mtvec_target | input | XLEN | Normal machine trap target |
| redirect_valid | output | 1 | Core must jump this cycle |
| redirect_pc | output | XLEN | Jump target |
| new_priv | output | 2 | Privilege after the jump |
| new_virt | output | 1 | Virtualization after the jump |
| clr_mprv | output | 1 | Clear the modify-privilege bit of machine status |
| illegal_instr | output | 1 | NMI return seen below machine mode |
| irq_enable | output | 1 | Ordinary interrupts may be taken |
| mprv_enable | output | 1 | Modify-privilege may act on loads and stores |

## Verification
On every cycle the assertions check these properties: the enable flag never falls except at NMI entry, it is clear after entry and set after a return, the saved privilege never holds the reserved code, saved virtualization is zero whenever the hypervisor is off, the saved PC is even, and an illegal return never redirects. Other behaviour can be shown only by the bench's scenarios. This covers the legalized value written into the status word, the exact saved PC and privilege after entry, and the return target. It also covers which request wins when entry, trap, return and a CSR write all arrive in the same cycle, and that the losing CSR write leaves its register untouched.

// File: rtl/rnmi_pkg.sv
package rnmi_pkg;

    typedef enum logic [1:0] {
        PRIV_U    = 2'd0,
        PRIV_S    = 2'd1,
        PRIV_RSVD = 2'd2,
        PRIV_M    = 2'd3
    } priv_e;

    localparam logic [11:0] ADDR_SCRATCH = 12'h740;
    localparam logic [11:0] ADDR_EPC     = 12'h741;
    localparam logic [11:0] ADDR_CAUSE   = 12'h742;
    localparam logic [11:0] ADDR_STATUS  = 12'h744;

    localparam int BIT_ENABLE   = 3;
    localparam int BIT_PVIRT    = 7;
    localparam int BIT_PPRIV_LO = 11;
    localparam int BIT_PPRIV_HI = 12;

    localparam logic [31:0] RETURN_OPCODE = 32'h7020_0073;

    typedef struct packed {
        logic  enable;
        logic  prev_virt;
        priv_e prev_priv;
    } nmi_status_t;

    // Map a requested privilege onto one the core implements.
    function automatic priv_e legal_priv(input logic [1:0] req,
                                         input bit has_s, input bit has_u);
        if (!has_u) return PRIV_M;
        case (req)
            2'd3:    return PRIV_M;
            2'd1:    return has_s ? PRIV_S : PRIV_U;
            default: return PRIV_U;
        endcase
    endfunction

endpackage

// File: rtl/rnmi_ret_decode.sv
module rnmi_ret_decode
    import rnmi_pkg::*;
(
    input  logic        instr_valid,
    input  logic [31:0] instr,
    input  logic [1:0]  cur_priv,
    output logic        ret_seen,
    output logic        ret_illegal
);
    logic opcode_match;

    always_comb begin
        opcode_match = instr_valid && (instr == RETURN_OPCODE);
        ret_seen     = opcode_match && (priv_e'(cur_priv) == PRIV_M);
        ret_illegal  = opcode_match && (priv_e'(cur_priv) != PRIV_M);
    end
endmodule

// File: rtl/rnmi_state.sv
module rnmi_state
    import rnmi_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter bit HAS_SMODE = 1'b1,
    parameter bit HAS_UMODE = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            csr_we,
    input  logic [11:0]     csr_addr,
    input  logic [XLEN-1:0] csr_wdata,
    input  logic            hyp_en,
    input  logic            take_entry,
    input  logic            take_ret,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [1:0]      cur_priv,
    input  logic            cur_virt,
    output logic [XLEN-1:0] scratch_q,
    output logic [XLEN-1:0] epc_q,
    output nmi_status_t     status_q,
    output logic [XLEN-1:0] csr_rdata,
    output logic            csr_hit
);
    localparam logic [XLEN-1:0] CAUSE_VALUE = {1'b1, {(XLEN-1){1'b0}}};
    localparam logic [XLEN-1:0] EVEN_MASK   = ~{{(XLEN-1){1'b0}}, 1'b1};

    logic wr_ok;
    assign wr_ok = csr_we && !take_entry && !take_ret;

    always_ff @(posedge clk) begin
        if (rst) begin
            scratch_q <= '0;
            epc_q     <= '0;
            status_q  <= '{enable: 1'b0, prev_virt: 1'b0, prev_priv: PRIV_U};
        end else begin
            if (take_entry) begin
                epc_q              <= cur_pc & EVEN_MASK;
                status_q.prev_priv <= legal_priv(cur_priv, HAS_SMODE, HAS_UMODE);
                status_q.prev_virt <= cur_virt & hyp_en;
                status_q.enable    <= 1'b0;
            end else if (take_ret) begin
                status_q.enable <= 1'b1;
            end else if (wr_ok) begin
                case (csr_addr)
                    ADDR_SCRATCH: scratch_q <= csr_wdata;
                    ADDR_EPC:     epc_q     <= csr_wdata & EVEN_MASK;
                    ADDR_STATUS: begin
                        status_q.enable    <= status_q.enable | csr_wdata[BIT_ENABLE];
                        status_q.prev_priv <= legal_priv(csr_wdata[BIT_PPRIV_HI:BIT_PPRIV_LO],
                                                         HAS_SMODE, HAS_UMODE);
                        if (hyp_en) status_q.prev_virt <= csr_wdata[BIT_PVIRT];
                    end
                    default: ;
                endcase
            end
            if (!hyp_en) status_q.prev_virt <= 1'b0;
        end
    end

    always_comb begin
        csr_hit   = 1'b1;
        csr_rdata = '0;
        case (csr_addr)
            ADDR_SCRATCH: csr_rdata = scratch_q;
            ADDR_EPC:     csr_rdata = epc_q;
            ADDR_CAUSE:   csr_rdata = CAUSE_VALUE;
            ADDR_STATUS: begin
                csr_rdata[BIT_ENABLE]                = status_q.enable;
                csr_rdata[BIT_PVIRT]                 = status_q.prev_virt;
                csr_rdata[BIT_PPRIV_HI:BIT_PPRIV_LO] = status_q.prev_priv;
            end
            default:      csr_hit = 1'b0;
        endcase
    end

    // R3
    nmie_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (status_q.enable && !take_entry) |=> status_q.enable);

    // R6
    entry_clears_chk: assert property (@(posedge clk) disable iff (rst)
        take_entry |=> !status_q.enable);

    // R7
    ret_sets_chk: assert property (@(posedge clk) disable iff (rst)
        take_ret |=> status_q.enable);

    // R4
    mnpp_legal_chk: assert property (@(posedge clk) disable iff (rst)
        status_q.prev_priv != PRIV_RSVD);

    // R4
    mnpv_hyp_chk: assert property (@(posedge clk) disable iff (rst)
        !hyp_en |=> !status_q.prev_virt);

    // R5
    epc_even_chk: assert property (@(posedge clk) disable iff (rst)
        !epc_q[0]);
endmodule

// File: rtl/rnmi_redirect.sv
module rnmi_redirect
    import rnmi_pkg::*;
#(
    parameter int              XLEN            = 32,
    parameter logic [XLEN-1:0] NMI_VECTOR      = 'h100,
    parameter logic [XLEN-1:0] RNMI_EXC_VECTOR = 'h200
) (
    input  logic            take_entry,
    input  logic            trap_taken,
    input  logic            take_ret,
    input  logic            nmie,
    input  logic [XLEN-1:0] mtvec_target,
    input  logic [XLEN-1:0] epc,
    input  priv_e           saved_priv,
    input  logic            saved_virt,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc,
    output logic [1:0]      new_priv,
    output logic            new_virt,
    output logic            clr_mprv
);
    always_comb begin
        redirect_valid = 1'b0;
        redirect_pc    = '0;
        new_priv       = PRIV_M;
        new_virt       = 1'b0;
        clr_mprv       = 1'b0;
        if (take_entry) begin
            redirect_valid = 1'b1;
            redirect_pc    = NMI_VECTOR;
        end else if (trap_taken) begin
            redirect_valid = 1'b1;
            redirect_pc    = nmie ? mtvec_target : RNMI_EXC_VECTOR;
        end else if (take_ret) begin
            redirect_valid = 1'b1;
            redirect_pc    = epc;
            new_priv       = saved_priv;
            new_virt       = saved_virt;
            clr_mprv       = (saved_priv != PRIV_M);
        end
    end
endmodule

// File: rtl/rnmi_ctrl.sv
module rnmi_ctrl
    import rnmi_pkg::*;
#(
    parameter int              XLEN            = 32,
    parameter logic [XLEN-1:0] NMI_VECTOR      = 'h100,
    parameter logic [XLEN-1:0] RNMI_EXC_VECTOR = 'h200,
    parameter bit              HAS_SMODE       = 1'b1,
    parameter bit              HAS_UMODE       = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            csr_we,
    input  logic [11:0]     csr_addr,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    output logic            csr_hit,
    input  logic            nmi_req,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [1:0]      cur_priv,
    input  logic            cur_virt,
    input  logic            hyp_en,
    input  logic            instr_valid,
    input  logic [31:0]     instr,
    input  logic            trap_taken,
    input  logic [XLEN-1:0] mtvec_target,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc,
    output logic [1:0]      new_priv,
    output logic            new_virt,
    output logic            clr_mprv,
    output logic            illegal_instr,
    output logic            irq_enable,
    output logic            mprv_enable
);
    logic            ret_seen;
    logic            ret_illegal;
    logic            take_entry;
    logic            take_ret;
    logic [XLEN-1:0] scratch_q;
    logic [XLEN-1:0] epc_q;
    nmi_status_t     status_q;

    rnmi_ret_decode u_decode (
        .instr_valid (instr_valid),
        .instr       (instr),
        .cur_priv    (cur_priv),
        .ret_seen    (ret_seen),
        .ret_illegal (ret_illegal)
    );

    assign take_entry    = nmi_req && status_q.enable;
    assign take_ret      = ret_seen && !take_entry && !trap_taken;
    assign illegal_instr = ret_illegal && !take_entry && !trap_taken;
    assign irq_enable    = status_q.enable;
    assign mprv_enable   = status_q.enable;

    rnmi_state #(
        .XLEN      (XLEN),
        .HAS_SMODE (HAS_SMODE),
        .HAS_UMODE (HAS_UMODE)
    ) u_state (
        .clk        (clk),
        .rst        (rst),
        .csr_we     (csr_we),
        .csr_addr   (csr_addr),
        .csr_wdata  (csr_wdata),
        .hyp_en     (hyp_en),
        .take_entry (take_entry),
        .take_ret   (take_ret),
        .cur_pc     (cur_pc),
        .cur_priv   (cur_priv),
        .cur_virt   (cur_virt),
        .scratch_q  (scratch_q),
        .epc_q      (epc_q),
        .status_q   (status_q),
        .csr_rdata  (csr_rdata),
        .csr_hit    (csr_hit)
    );

    rnmi_redirect #(
        .XLEN            (XLEN),
        .NMI_VECTOR      (NMI_VECTOR),
        .RNMI_EXC_VECTOR (RNMI_EXC_VECTOR)
    ) u_redirect (
        .take_entry     (take_entry),
        .trap_taken     (trap_taken),
        .take_ret       (take_ret),
        .nmie           (status_q.enable),
        .mtvec_target   (mtvec_target),
        .epc            (epc_q),
        .saved_priv     (status_q.prev_priv),
        .saved_virt     (status_q.prev_virt),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .new_priv       (new_priv),
        .new_virt       (new_virt),
        .clr_mprv       (clr_mprv)
    );

    // R9
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (illegal_instr && !nmi_req && !trap_taken) |-> !redirect_valid);

    // R9
    illegal_keeps_state_chk: assert property (@(posedge clk) disable iff (rst)
        (illegal_instr && !csr_we) |=> ($stable(status_q) && $stable(epc_q)));

    // R8
    clr_mprv_chk: assert property (@(posedge clk) disable iff (rst)
        clr_mprv |-> (redirect_valid && new_priv != 2'd3));

    // R11
    trap_target_chk: assert property (@(posedge clk) disable iff (rst)
        (trap_taken && !nmi_req && !irq_enable) |-> (redirect_pc == RNMI_EXC_VECTOR));
endmodule

// File: tb/rnmi_ctrl_bench.sv
module rnmi_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] NMI_VEC = 32'h0000_0100;
    localparam logic [31:0] EXC_VEC = 32'h0000_0200;
    localparam logic [31:0] OP_RET  = 32'h7020_0073;
    localparam logic [11:0] A_SCR = 12'h740, A_EPC = 12'h741, A_CAUSE = 12'h742, A_STAT = 12'h744;

    typedef struct packed {
        logic        hyp;
        logic        nmie_case;
        logic [31:0] wdata;
        logic [31:0] expect_val;
    } vec_t;

    localparam vec_t STATUS_VECS [0:6] = '{
        '{1'b0, 1'b0, 32'h0000_1880, 32'h0000_1800},
        '{1'b1, 1'b0, 32'h0000_0880, 32'h0000_0880},
        '{1'b1, 1'b0, 32'h0000_1000, 32'h0000_0000},
        '{1'b1, 1'b1, 32'hFFFF_FFFF, 32'h0000_1888},
        '{1'b1, 1'b1, 32'h0000_0000, 32'h0000_0008},
        '{1'b1, 1'b0, 32'h0000_0880, 32'h0000_0888},
        '{1'b0, 1'b1, 32'h0000_0000, 32'h0000_0008}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic csr_we = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic csr_hit;
    logic nmi_req = 1'b0;
    logic [31:0] cur_pc = '0;
    logic [1:0] cur_priv = 2'd3;
    logic cur_virt = 1'b0;
    logic hyp_en = 1'b0;
    logic instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic trap_taken = 1'b0;
    logic [31:0] mtvec_target = 32'h0000_4000;
    logic redirect_valid;
    logic [31:0] redirect_pc;
    logic [1:0] new_priv;
    logic new_virt, clr_mprv, illegal_instr, irq_enable, mprv_enable;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rnmi_ctrl u_rnmi_ctrl (
        .clk(clk), .rst(rst), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_hit(csr_hit),
        .nmi_req(nmi_req), .cur_pc(cur_pc), .cur_priv(cur_priv),
        .cur_virt(cur_virt), .hyp_en(hyp_en), .instr_valid(instr_valid),
        .instr(instr), .trap_taken(trap_taken), .mtvec_target(mtvec_target),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .new_priv(new_priv), .new_virt(new_virt), .clr_mprv(clr_mprv),
        .illegal_instr(illegal_instr), .irq_enable(irq_enable),
        .mprv_enable(mprv_enable)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic csr_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic csr_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        csr_addr = a;
        #1 d = csr_rdata;
    endtask

    task automatic clear_inputs();
        nmi_req = 1'b0; trap_taken = 1'b0; instr_valid = 1'b0; csr_we = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        csr_read(A_STAT, rd);  check("R1", "status after reset", rd, 32'h0);
        csr_read(A_SCR, rd);   check("R1", "scratch after reset", rd, 32'h0);
        csr_read(A_EPC, rd);   check("R1", "epc after reset", rd, 32'h0);
        check("R1", "redirect after reset", 32'(redirect_valid), 32'h0);
        check("R1", "illegal after reset", 32'(illegal_instr), 32'h0);
        check("R10", "irq_enable after reset", 32'(irq_enable), 32'h0);
        check("R10", "mprv_enable after reset", 32'(mprv_enable), 32'h0);

        // R2 map, cause, unmapped
        csr_read(A_CAUSE, rd); check("R2", "cause", rd, 32'h8000_0000);
        csr_write(A_CAUSE, 32'h0000_1234);
        csr_read(A_CAUSE, rd); check("R2", "cause after write", rd, 32'h8000_0000);
        csr_read(12'h743, rd);
        check("R2", "unmapped rdata", rd, 32'h0);
        check("R2", "unmapped hit", 32'(csr_hit), 32'h0);
        csr_write(A_SCR, 32'hDEAD_BEEF);
        csr_read(A_SCR, rd);   check("R2", "scratch rw", rd, 32'hDEAD_BEEF);

        // R5 epc low bit
        csr_write(A_EPC, 32'h0000_1235);
        csr_read(A_EPC, rd);   check("R5", "epc write odd", rd, 32'h0000_1234);

        // R6 request ignored while disabled
        @(negedge clk); nmi_req = 1'b1; cur_pc = 32'h0000_3000;
        #1 check("R6", "no redirect when disabled", 32'(redirect_valid), 32'h0);
        @(negedge clk); nmi_req = 1'b0;
        csr_read(A_STAT, rd);  check("R6", "status untouched", rd, 32'h0);
        csr_read(A_EPC, rd);   check("R6", "epc untouched", rd, 32'h0000_1234);

        // R11 trap while disabled
        @(negedge clk); trap_taken = 1'b1;
        #1 check("R11", "trap pc disabled", redirect_pc, EXC_VEC);
        @(negedge clk); trap_taken = 1'b0;

        // Status table: R3 and R4
        for (int i = 0; i <= 6; i++) begin
            hyp_en = STATUS_VECS[i].hyp;
            csr_write(A_STAT, STATUS_VECS[i].wdata);
            csr_read(A_STAT, rd);
            check(STATUS_VECS[i].nmie_case ? "R3" : "R4", "status table", rd,
                  STATUS_VECS[i].expect_val);
        end

        // R10, R11 with enable set
        check("R10", "irq_enable set", 32'(irq_enable), 32'h1);
        check("R10", "mprv_enable set", 32'(mprv_enable), 32'h1);
        @(negedge clk); trap_taken = 1'b1;
        #1 check("R11", "trap pc enabled", redirect_pc, 32'h0000_4000);
        @(negedge clk); trap_taken = 1'b0;

        // R6 entry
        @(negedge clk);
        hyp_en = 1'b1; cur_priv = 2'd1; cur_virt = 1'b1; cur_pc = 32'h8000_1001; nmi_req = 1'b1;
        #1;
        check("R6", "entry valid", 32'(redirect_valid), 32'h1);
        check("R6", "entry pc", redirect_pc, NMI_VEC);
        check("R6", "entry priv", 32'(new_priv), 32'h3);
        check("R6", "entry virt", 32'(new_virt), 32'h0);
        @(negedge clk); nmi_req = 1'b0;
        csr_read(A_STAT, rd);  check("R6", "status after entry", rd, 32'h0000_0880);
        csr_read(A_EPC, rd);   check("R5", "epc after entry", rd, 32'h8000_1000);
        check("R10", "irq_enable after entry", 32'(irq_enable), 32'h0);

        // R9 return below M
        @(negedge clk); instr_valid = 1'b1; instr = OP_RET; cur_priv = 2'd1;
        #1;
        check("R9", "illegal flag", 32'(illegal_instr), 32'h1);
        check("R9", "no redirect", 32'(redirect_valid), 32'h0);
        @(negedge clk); instr_valid = 1'b0; cur_priv = 2'd3;
        csr_read(A_STAT, rd);  check("R9", "status unchanged", rd, 32'h0000_0880);

        // R7 near-miss encoding
        @(negedge clk); instr_valid = 1'b1; instr = 32'h3020_0073;
        #1 check("R7", "other opcode no redirect", 32'(redirect_valid), 32'h0);
        @(negedge clk); instr_valid = 1'b0;
        csr_read(A_STAT, rd);  check("R7", "status after near-miss", rd, 32'h0000_0880);

        // R7, R8 return to S with virt
        @(negedge clk); instr_valid = 1'b1; instr = OP_RET;
        #1;
        check("R7", "ret valid", 32'(redirect_valid), 32'h1);
        check("R7", "ret pc", redirect_pc, 32'h8000_1000);
        check("R7", "ret priv", 32'(new_priv), 32'h1);
        check("R7", "ret virt", 32'(new_virt), 32'h1);
        check("R8", "clr_mprv to S", 32'(clr_mprv), 32'h1);
        @(negedge clk); instr_valid = 1'b0;
        csr_read(A_STAT, rd);  check("R7", "status after ret", rd, 32'h0000_0888);

        // R8 return to M
        csr_write(A_STAT, 32'h0000_1800);
        csr_read(A_STAT, rd);  check("R4", "status mnpp M", rd, 32'h0000_1808);
        @(negedge clk); instr_valid = 1'b1; instr = OP_RET;
        #1;
        check("R8", "clr_mprv to M", 32'(clr_mprv), 32'h0);
        check("R7", "ret priv M", 32'(new_priv), 32'h3);
        @(negedge clk); instr_valid = 1'b0;

        // R12 all at once
        @(negedge clk);
        cur_virt = 1'b0; cur_pc = 32'h0000_2000; nmi_req = 1'b1; trap_taken = 1'b1;
        instr_valid = 1'b1; instr = OP_RET; csr_we = 1'b1; csr_addr = A_SCR; csr_wdata = 32'h0000_5555;
        #1;
        check("R12", "entry beats trap and ret", redirect_pc, NMI_VEC);
        check("R12", "no illegal", 32'(illegal_instr), 32'h0);
        @(negedge clk); clear_inputs();
        csr_read(A_SCR, rd);   check("R12", "scratch write dropped at entry", rd, 32'hDEAD_BEEF);
        csr_read(A_STAT, rd);  check("R12", "status after combined entry", rd, 32'h0000_1800);
        csr_read(A_EPC, rd);   check("R6", "epc combined", rd, 32'h0000_2000);

        // R12 trap beats return
        @(negedge clk); trap_taken = 1'b1; instr_valid = 1'b1; instr = OP_RET;
        #1 check("R12", "trap beats ret", redirect_pc, EXC_VEC);
        @(negedge clk); clear_inputs();
        csr_read(A_STAT, rd);  check("R12", "ret suppressed by trap", rd, 32'h0000_1800);

        // R12 write dropped during return
        @(negedge clk); instr_valid = 1'b1; instr = OP_RET;
        csr_we = 1'b1; csr_addr = A_SCR; csr_wdata = 32'h0000_7777;
        #1 check("R12", "ret pc", redirect_pc, 32'h0000_2000);
        @(negedge clk); clear_inputs();
        csr_read(A_SCR, rd);   check("R12", "scratch write dropped at ret", rd, 32'hDEAD_BEEF);
        csr_read(A_STAT, rd);  check("R12", "status after ret", rd, 32'h0000_1808);
        check("R10", "irq_enable final", 32'(irq_enable), 32'h1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule